// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 SDRAM from power-up to ready for use, once supply and clock are stable. After reset it keeps the clock enable low and the command bus idle for a long settling period. It then raises the clock enable and issues a fixed chain of commands: a precharge of all banks, writes to the four mode registers (the DLL is enabled and then reset), a second precharge, a parameterised number of refreshes, and the operating mode write. It finishes with a pair of writes to the extended mode register that enter and then leave the default drive-impedance state. Every wait is a cycle count derived at elaboration time from a clock-period parameter, rounded up. No read or write traffic is issued.

The operating fields of the mode registers come from configuration inputs. These inputs must hold still for the whole sequence. A memory controller keeps its normal command path off the bus until `done` goes high. `done` goes high at the later of two points: the end of the command chain, or the end of the DLL lock window that starts at the DLL reset write.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset is released, `cke` stays low and the bus carries NOP for ceil(PWRUP_NS*1000/CLK_PERIOD_PS) cycles, then `cke` goes high.
- R2: Once `cke` is high it stays high until the next reset.
- R3: Exactly ceil(CKE_SETUP_NS*1000/CLK_PERIOD_PS) cycles after `cke` rises, a PRECHARGE with `addr[10]`=1 and `ba`=0 is issued.
- R4: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as NOP=0111, PRECHARGE=0010, REFRESH=0001 and LOAD MODE=0000. Each command lasts one cycle. Every other cycle is NOP with `ba` and `addr` zero.
- R5: After the first precharge, four LOAD MODE writes follow in this order. First `ba`=010 with `addr[7]`=`cfg_srt_hot` and all other bits 0. Second `ba`=011 with all bits 0. Third `ba`=001 with the extended word below and bits 9:7 = 000. Fourth `ba`=000 with the mode word below and `addr[8]`=1 (DLL reset).
- R6: The mode word has `addr[2:0]`=burst length, `addr[3]`=interleave, `addr[6:4]`=CAS latency, `addr[7]`=0, `addr[11:9]`=write recovery and `addr[12]`=slow power-down exit. The extended word has `addr[0]`=0, `addr[1]`=reduced drive, `addr[5:3]`=additive latency, `addr[10]`=strobe complement disable and all other bits 0.
- R7: After the DLL reset write come a PRECHARGE (`addr[10]`=1), then max(REF_COUNT,2) REFRESH commands, then a LOAD MODE with `ba`=000, the mode word and `addr[8]`=0.
- R8: Two writes to `ba`=001 then follow: the extended word with bits 9:7 = 111, and then the extended word with bits 9:7 = 000.
- R9: The next command follows exactly T_MRD_CYC cycles after a LOAD MODE, ceil(T_RP_NS*1000/CLK_PERIOD_PS) cycles after a PRECHARGE, and ceil(T_RFC_NS*1000/CLK_PERIOD_PS) cycles after a REFRESH.
- R10: `done` rises in the later of two cycles: T_MRD_CYC cycles after the last extended write, or DLL_LOCK_CYC cycles after the DLL reset write. It then stays high until reset.
- R11: A reset at any point returns the outputs to `cke` low, NOP and `done` low, and the whole sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_burst_interleave | input | 1 | Interleaved burst ordering |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_write_rec | input | 3 | Write recovery code |
| cfg_pd_slow_exit | input | 1 | Slow power-down exit select |
| cfg_add_lat | input | 3 | Additive latency code |
| cfg_drive_reduced | input | 1 | Reduced output drive strength |
| cfg_dqs_diff_off | input | 1 | Disable complementary data strobe |
| cfg_srt_hot | input | 1 | High-temperature self-refresh bit |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| addr | output | ADDR_W | Address bus |
| done | output | 1 | Memory ready for normal traffic |

## Verification
Several corner cases are targeted. The first is the exact cycle on which `cke` rises and the exact cycle of the first precharge: an off-by-one timer would move either edge by a cycle. The refresh loop is run with its minimum count, so a design that counts refreshes wrongly shifts every later command. The `done` edge is checked where the DLL lock window ends after the command chain. A design that raised `done` at the end of the chain would assert it about 124 cycles too early. A reset is applied just after the DLL reset write, with the lock counter part-way through. A design that does not clear that counter would raise `done` early on the second pass, and the bench catches it. Two configurations with complementary field values expose any swapped or misplaced mode bit.

// File: rtl/ddr2_init_pkg.sv
// Shared types for the DDR2 initialization sequencer.
// Assumes: commands are encoded {cs_n,ras_n,cas_n,we_n}.
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_CKE_WAIT,
        ST_PREA_1,
        ST_LM_EMR2,
        ST_LM_EMR3,
        ST_LM_EMR_DLL,
        ST_LM_MR_RST,
        ST_PREA_2,
        ST_REF,
        ST_LM_MR_OP,
        ST_LM_OCD_DFLT,
        ST_LM_OCD_EXIT,
        ST_FINISHED
    } init_step_e;

    typedef enum logic [3:0] {
        CMD_LOAD_MODE = 4'b0000,
        CMD_REFRESH   = 4'b0001,
        CMD_PRECHARGE = 4'b0010,
        CMD_NOP       = 4'b0111
    } ddr_cmd_e;

    typedef struct packed {
        logic [2:0] burst_len;
        logic       burst_interleave;
        logic [2:0] cas_lat;
        logic [2:0] write_rec;
        logic       pd_slow_exit;
        logic [2:0] add_lat;
        logic       drive_reduced;
        logic       dqs_diff_off;
        logic       srt_hot;
    } mode_cfg_t;

    // Convert a time in ns to a whole number of clock cycles, rounding up.
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned period_ps);
        longint unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
// Loadable down-counter that times the gap between sequence steps.
// Assumes: load has priority; the count holds at zero until reloaded.
module ddr2_init_timer #(
    parameter int unsigned W       = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= W'(RST_VAL);
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_lock_cnt.sv
// Counts cycles since the DLL reset write and flags when the lock window ends.
// Assumes: start is a one-cycle pulse; the count saturates at LOCK_CYC.
module ddr2_init_lock_cnt #(
    parameter int unsigned LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic reached
);

    localparam int unsigned CW = $clog2(LOCK_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    // Arm on the DLL reset write, then count up to the lock length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (armed_q && cnt_q != CW'(LOCK_CYC)) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign reached = armed_q && (cnt_q == CW'(LOCK_CYC));

endmodule

// File: rtl/ddr2_init_cmd_gen.sv
// Maps a sequence step and the configuration to command, bank and address.
// Assumes: ADDR_W >= 13; steps that issue nothing return an idle NOP.
module ddr2_init_cmd_gen
    import ddr2_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  init_step_e        step,
    input  mode_cfg_t         cfg,
    output ddr_cmd_e          cmd,
    output logic [2:0]        ba,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] mode_word;
    logic [ADDR_W-1:0] ext_word;

    // Assemble the operating mode word (DLL reset bit cleared).
    always_comb begin
        mode_word        = '0;
        mode_word[2:0]   = cfg.burst_len;
        mode_word[3]     = cfg.burst_interleave;
        mode_word[6:4]   = cfg.cas_lat;
        mode_word[11:9]  = cfg.write_rec;
        mode_word[12]    = cfg.pd_slow_exit;
    end

    // Assemble the extended word with the DLL enabled and the drive state bits cleared.
    always_comb begin
        ext_word         = '0;
        ext_word[1]      = cfg.drive_reduced;
        ext_word[5:3]    = cfg.add_lat;
        ext_word[10]     = cfg.dqs_diff_off;
    end

    // Select the bus contents for the given step.
    always_comb begin
        cmd  = CMD_NOP;
        ba   = 3'b000;
        addr = '0;
        unique case (step)
            ST_PREA_1, ST_PREA_2: begin
                cmd      = CMD_PRECHARGE;
                addr[10] = 1'b1;
            end
            ST_LM_EMR2: begin
                cmd     = CMD_LOAD_MODE;
                ba      = 3'b010;
                addr[7] = cfg.srt_hot;
            end
            ST_LM_EMR3: begin
                cmd = CMD_LOAD_MODE;
                ba  = 3'b011;
            end
            ST_LM_EMR_DLL, ST_LM_OCD_EXIT: begin
                cmd  = CMD_LOAD_MODE;
                ba   = 3'b001;
                addr = ext_word;
            end
            ST_LM_OCD_DFLT: begin
                cmd       = CMD_LOAD_MODE;
                ba        = 3'b001;
                addr      = ext_word;
                addr[9:7] = 3'b111;
            end
            ST_LM_MR_RST: begin
                cmd     = CMD_LOAD_MODE;
                addr    = mode_word;
                addr[8] = 1'b1;
            end
            ST_LM_MR_OP: begin
                cmd  = CMD_LOAD_MODE;
                addr = mode_word;
            end
            ST_REF: begin
                cmd = CMD_REFRESH;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up initialization sequencer (top).
// Walks a fixed chain of steps; each command lasts one cycle, followed by
// NOPs until the gap for that command has elapsed. All bus outputs are registered.
// Assumes: configuration inputs hold still from reset release until done.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned PWRUP_NS      = 200000,
    parameter int unsigned CKE_SETUP_NS  = 400,
    parameter int unsigned T_RP_NS       = 15,
    parameter int unsigned T_RFC_NS      = 128,
    parameter int unsigned T_MRD_CYC     = 2,
    parameter int unsigned DLL_LOCK_CYC  = 200,
    parameter int unsigned REF_COUNT     = 2,
    parameter int unsigned ADDR_W        = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [2:0]        cfg_write_rec,
    input  logic              cfg_pd_slow_exit,
    input  logic [2:0]        cfg_add_lat,
    input  logic              cfg_drive_reduced,
    input  logic              cfg_dqs_diff_off,
    input  logic              cfg_srt_hot,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [2:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam int unsigned PWRUP_CYC = ns_to_cycles(PWRUP_NS, CLK_PERIOD_PS);
    localparam int unsigned CKE_CYC   = ns_to_cycles(CKE_SETUP_NS, CLK_PERIOD_PS);
    localparam int unsigned RP_CYC    = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
    localparam int unsigned RFC_CYC   = ns_to_cycles(T_RFC_NS, CLK_PERIOD_PS);
    localparam int unsigned MRD_CYC   = (T_MRD_CYC < 1) ? 1 : T_MRD_CYC;
    localparam int unsigned REFS      = (REF_COUNT < 2) ? 2 : REF_COUNT;
    localparam int unsigned TMR_MAX   = PWRUP_CYC + CKE_CYC + RP_CYC + RFC_CYC + MRD_CYC;
    localparam int unsigned TMR_W     = $clog2(TMR_MAX + 1);
    localparam int unsigned RC_W      = $clog2(REFS + 1);

    init_step_e        step_q, step_nx;
    logic              advance;
    logic              tmr_expired;
    logic [TMR_W-1:0]  tmr_load_val;
    logic [RC_W-1:0]   ref_done_q;
    logic              lock_start;
    logic              lock_reached;
    logic              cke_q;
    ddr_cmd_e          gen_cmd;
    logic [2:0]        gen_ba;
    logic [ADDR_W-1:0] gen_addr;
    ddr_cmd_e          cmd_q;
    logic [2:0]        ba_q;
    logic [ADDR_W-1:0] addr_q;
    mode_cfg_t         cfg;

    // Gather the configuration inputs into one record.
    always_comb begin
        cfg.burst_len        = cfg_burst_len;
        cfg.burst_interleave = cfg_burst_interleave;
        cfg.cas_lat          = cfg_cas_lat;
        cfg.write_rec        = cfg_write_rec;
        cfg.pd_slow_exit     = cfg_pd_slow_exit;
        cfg.add_lat          = cfg_add_lat;
        cfg.drive_reduced    = cfg_drive_reduced;
        cfg.dqs_diff_off     = cfg_dqs_diff_off;
        cfg.srt_hot          = cfg_srt_hot;
    end

    // Pick the step that follows the current one.
    always_comb begin
        unique case (step_q)
            ST_PWRUP:       step_nx = ST_CKE_WAIT;
            ST_CKE_WAIT:    step_nx = ST_PREA_1;
            ST_PREA_1:      step_nx = ST_LM_EMR2;
            ST_LM_EMR2:     step_nx = ST_LM_EMR3;
            ST_LM_EMR3:     step_nx = ST_LM_EMR_DLL;
            ST_LM_EMR_DLL:  step_nx = ST_LM_MR_RST;
            ST_LM_MR_RST:   step_nx = ST_PREA_2;
            ST_PREA_2:      step_nx = ST_REF;
            ST_REF:         step_nx = (ref_done_q == RC_W'(REFS - 1)) ? ST_LM_MR_OP : ST_REF;
            ST_LM_MR_OP:    step_nx = ST_LM_OCD_DFLT;
            ST_LM_OCD_DFLT: step_nx = ST_LM_OCD_EXIT;
            ST_LM_OCD_EXIT: step_nx = ST_FINISHED;
            default:        step_nx = ST_FINISHED;
        endcase
    end

    // Timer reload: the gap that must follow the step being entered.
    always_comb begin
        unique case (step_nx)
            ST_CKE_WAIT:          tmr_load_val = TMR_W'(CKE_CYC - 1);
            ST_PREA_1, ST_PREA_2: tmr_load_val = TMR_W'(RP_CYC - 1);
            ST_REF:               tmr_load_val = TMR_W'(RFC_CYC - 1);
            ST_FINISHED:          tmr_load_val = '0;
            default:              tmr_load_val = TMR_W'(MRD_CYC - 1);
        endcase
    end

    assign advance    = tmr_expired && (step_q != ST_FINISHED);
    assign lock_start = advance && (step_nx == ST_LM_MR_RST);

    ddr2_init_timer #(
        .W       (TMR_W),
        .RST_VAL (PWRUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (advance),
        .load_val (tmr_load_val),
        .expired  (tmr_expired)
    );

    ddr2_init_lock_cnt #(
        .LOCK_CYC (DLL_LOCK_CYC)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (lock_start),
        .reached (lock_reached)
    );

    ddr2_init_cmd_gen #(
        .ADDR_W (ADDR_W)
    ) u_gen (
        .step (step_nx),
        .cfg  (cfg),
        .cmd  (gen_cmd),
        .ba   (gen_ba),
        .addr (gen_addr)
    );

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n)       step_q <= ST_PWRUP;
        else if (advance) step_q <= step_nx;
    end

    // Count refreshes issued so far.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ref_done_q <= '0;
        else if (advance && step_q == ST_REF) ref_done_q <= ref_done_q + 1'b1;
    end

    // Clock enable: raised when the power-up wait ends, never lowered until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cke_q <= 1'b0;
        else if (advance && step_q == ST_PWRUP) cke_q <= 1'b1;
    end

    // Bus register: one cycle of command on entry to a step, idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            ba_q   <= 3'b000;
            addr_q <= '0;
        end else if (advance) begin
            cmd_q  <= gen_cmd;
            ba_q   <= gen_ba;
            addr_q <= gen_addr;
        end else begin
            cmd_q  <= CMD_NOP;
            ba_q   <= 3'b000;
            addr_q <= '0;
        end
    end

    assign cke                        = cke_q;
    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign ba                         = ba_q;
    assign addr                       = addr_q;
    assign done                       = (step_q == ST_FINISHED) && lock_reached;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
// Protocol checker for the initialization sequencer, bound to its top.
// Assumes: the same command encoding and DLL lock length as the design.
module ddr2_init_seq_chk #(
    parameter int unsigned T_MRD_CYC    = 2,
    parameter int unsigned DLL_LOCK_CYC = 200,
    parameter int unsigned ADDR_W       = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [2:0]        ba,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);

    localparam int unsigned LW = $clog2(DLL_LOCK_CYC + 1);
    localparam int unsigned GW = $clog2(T_MRD_CYC + 2);

    logic [3:0]    bus_cmd;
    logic          is_nop;
    logic          is_lm;
    logic          dll_rst_seen;
    logic [LW-1:0] since_dll_q;
    logic          dll_armed_q;
    logic [GW-1:0] gap_q;
    logic          prev_lm_q;

    assign bus_cmd      = {cs_n, ras_n, cas_n, we_n};
    assign is_nop       = (bus_cmd == 4'b0111);
    assign is_lm        = (bus_cmd == 4'b0000);
    assign dll_rst_seen = is_lm && (ba == 3'b000) && addr[8];

    // Cycles since the DLL reset write, saturating at the lock length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_dll_q <= '0;
            dll_armed_q <= 1'b0;
        end else if (dll_rst_seen) begin
            since_dll_q <= LW'(1);
            dll_armed_q <= 1'b1;
        end else if (dll_armed_q && since_dll_q != LW'(DLL_LOCK_CYC)) begin
            since_dll_q <= since_dll_q + 1'b1;
        end
    end

    // Cycles since the last command, and whether that command was a LOAD MODE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= '0;
            prev_lm_q <= 1'b0;
        end else if (!is_nop) begin
            gap_q     <= GW'(1);
            prev_lm_q <= is_lm;
        end else if (gap_q != GW'(T_MRD_CYC + 1)) begin
            gap_q     <= gap_q + 1'b1;
        end
    end

    assert_nop_while_cke_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> is_nop);

    assert_cke_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    assert_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop |-> (ba == 3'b000 && addr == '0));

    assert_cmd_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_nop || is_lm || bus_cmd == 4'b0001 || bus_cmd == 4'b0010));

    assert_mrd_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_nop && prev_lm_q) |-> (gap_q >= GW'(T_MRD_CYC)));

    assert_done_after_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dll_armed_q && since_dll_q >= LW'(DLL_LOCK_CYC)));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_done_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cke && is_nop));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .T_MRD_CYC    (T_MRD_CYC),
    .DLL_LOCK_CYC (DLL_LOCK_CYC),
    .ADDR_W       (ADDR_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .addr  (addr),
    .done  (done)
);

// File: tb/ddr2_init_seq_tb.sv
// Bench: a behavioural schedule of expected bus events, compared every clock.
module ddr2_init_seq_tb;

    localparam int CLK_PERIOD_PS = 4000;
    localparam int PWRUP_NS      = 200000;
    localparam int CKE_SETUP_NS  = 400;
    localparam int T_RP_NS       = 15;
    localparam int T_RFC_NS      = 128;
    localparam int T_MRD_CYC     = 2;
    localparam int DLL_LOCK_CYC  = 200;
    localparam int REF_COUNT     = 2;
    localparam int ADDR_W        = 14;

    // Expected cycle counts, from the requirement formulas (ceil of ns / period).
    localparam int PWRUP_CYC = (PWRUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int CKE_CYC   = (CKE_SETUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int RP_CYC    = (T_RP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int RFC_CYC   = (T_RFC_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    typedef struct {
        int              cyc;
        logic [3:0]      cmd;
        logic [2:0]      ba;
        logic [ADDR_W-1:0] addr;
        string           tag;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_burst_len = 3'd0;
    logic       cfg_burst_interleave = 1'b0;
    logic [2:0] cfg_cas_lat = 3'd0;
    logic [2:0] cfg_write_rec = 3'd0;
    logic       cfg_pd_slow_exit = 1'b0;
    logic [2:0] cfg_add_lat = 3'd0;
    logic       cfg_drive_reduced = 1'b0;
    logic       cfg_dqs_diff_off = 1'b0;
    logic       cfg_srt_hot = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, done;
    logic [2:0] ba;
    logic [ADDR_W-1:0] addr;

    ev_t sched[$];
    int  done_cyc;
    int  dll_cyc;
    int  total = 0;
    int  bad = 0;
    int  edges = 0;
    bit  finished = 0;

    always #2ns clk = ~clk;

    ddr2_init_seq #(
        .CLK_PERIOD_PS (CLK_PERIOD_PS), .PWRUP_NS (PWRUP_NS), .CKE_SETUP_NS (CKE_SETUP_NS),
        .T_RP_NS (T_RP_NS), .T_RFC_NS (T_RFC_NS), .T_MRD_CYC (T_MRD_CYC),
        .DLL_LOCK_CYC (DLL_LOCK_CYC), .REF_COUNT (REF_COUNT), .ADDR_W (ADDR_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_burst_len (cfg_burst_len), .cfg_burst_interleave (cfg_burst_interleave),
        .cfg_cas_lat (cfg_cas_lat), .cfg_write_rec (cfg_write_rec),
        .cfg_pd_slow_exit (cfg_pd_slow_exit), .cfg_add_lat (cfg_add_lat),
        .cfg_drive_reduced (cfg_drive_reduced), .cfg_dqs_diff_off (cfg_dqs_diff_off),
        .cfg_srt_hot (cfg_srt_hot),
        .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .done (done)
    );

    // R6: mode word field positions.
    function automatic logic [ADDR_W-1:0] mode_word(input bit dll_rst);
        logic [ADDR_W-1:0] w = '0;
        w[2:0]  = cfg_burst_len;
        w[3]    = cfg_burst_interleave;
        w[6:4]  = cfg_cas_lat;
        w[8]    = dll_rst;
        w[11:9] = cfg_write_rec;
        w[12]   = cfg_pd_slow_exit;
        return w;
    endfunction

    // R6: extended word field positions, with the drive state in bits 9:7.
    function automatic logic [ADDR_W-1:0] ext_word(input logic [2:0] ocd);
        logic [ADDR_W-1:0] w = '0;
        w[1]   = cfg_drive_reduced;
        w[5:3] = cfg_add_lat;
        w[9:7] = ocd;
        w[10]  = cfg_dqs_diff_off;
        return w;
    endfunction

    task automatic push(input int c, input logic [3:0] cmd, input logic [2:0] b,
                        input logic [ADDR_W-1:0] a, input string tag);
        ev_t e;
        e.cyc = c; e.cmd = cmd; e.ba = b; e.addr = a; e.tag = tag;
        sched.push_back(e);
    endtask

    // Build the expected command timeline (cycle = edges since reset release).
    task automatic build();
        int t;
        logic [ADDR_W-1:0] a10;
        logic [ADDR_W-1:0] e2;
        a10 = '0; a10[10] = 1'b1;
        e2 = '0; e2[7] = cfg_srt_hot;
        sched.delete();
        t = PWRUP_CYC + CKE_CYC;
        push(t, 4'b0010, 3'b000, a10, "R3");                     t += RP_CYC;
        push(t, 4'b0000, 3'b010, e2, "R5,R9");                   t += T_MRD_CYC;
        push(t, 4'b0000, 3'b011, '0, "R5");                      t += T_MRD_CYC;
        push(t, 4'b0000, 3'b001, ext_word(3'b000), "R5,R6");     t += T_MRD_CYC;
        dll_cyc = t;
        push(t, 4'b0000, 3'b000, mode_word(1'b1), "R5,R6");      t += T_MRD_CYC;
        push(t, 4'b0010, 3'b000, a10, "R7");                     t += RP_CYC;
        for (int i = 0; i < REF_COUNT; i++) begin
            push(t, 4'b0001, 3'b000, '0, "R7,R9");               t += RFC_CYC;
        end
        push(t, 4'b0000, 3'b000, mode_word(1'b0), "R6,R7");      t += T_MRD_CYC;
        push(t, 4'b0000, 3'b001, ext_word(3'b111), "R8");        t += T_MRD_CYC;
        push(t, 4'b0000, 3'b001, ext_word(3'b000), "R8");        t += T_MRD_CYC;
        done_cyc = (t > dll_cyc + DLL_LOCK_CYC) ? t : dll_cyc + DLL_LOCK_CYC;
    endtask

    task automatic check(input bit ok, input string req, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    // Compare the bus against the expectation for cycle k (called after a negedge).
    task automatic compare(input int k);
        logic [3:0] ecmd = 4'b0111;
        logic [2:0] eba = '0;
        logic [ADDR_W-1:0] eaddr = '0;
        logic ecke, edone;
        string tag = "R4";
        bit ok;
        if (sched.size() > 0 && sched[0].cyc == k) begin
            ecmd = sched[0].cmd; eba = sched[0].ba; eaddr = sched[0].addr; tag = sched[0].tag;
            void'(sched.pop_front());
        end
        ecke  = (k >= PWRUP_CYC);
        edone = (k >= done_cyc);
        if (cke !== ecke) tag = "R1,R2";
        else if (done !== edone) tag = "R10";
        ok = ({cs_n, ras_n, cas_n, we_n} === ecmd) && (ba === eba) && (addr === eaddr)
             && (cke === ecke) && (done === edone);
        check(ok, tag, $sformatf("k=%0d act cke=%b cmd=%b ba=%b addr=%h done=%b exp cke=%b cmd=%b ba=%b addr=%h done=%b",
              k, cke, {cs_n, ras_n, cas_n, we_n}, ba, addr, done, ecke, ecmd, eba, eaddr, edone));
    endtask

    task automatic check_idle(input string req);
        check(cke === 1'b0 && {cs_n, ras_n, cas_n, we_n} === 4'b0111 && ba === 3'b000
              && addr === '0 && done === 1'b0, req,
              $sformatf("reset state act cke=%b cmd=%b ba=%b addr=%h done=%b exp cke=0 cmd=0111 ba=000 addr=0 done=0",
              cke, {cs_n, ras_n, cas_n, we_n}, ba, addr, done));
    endtask

    // Release reset and compare every cycle up to and including cycle last.
    task automatic run_to(input int last);
        build();
        rst_n = 1'b1;
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            compare(k);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        edges++;
        if (edges >= 195000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog act edges=%0d exp below 195000", edges);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Configuration A.
        cfg_burst_len = 3'b010; cfg_burst_interleave = 1'b0; cfg_cas_lat = 3'b101;
        cfg_write_rec = 3'b011; cfg_pd_slow_exit = 1'b1; cfg_add_lat = 3'b010;
        cfg_drive_reduced = 1'b0; cfg_dqs_diff_off = 1'b1; cfg_srt_hot = 1'b1;
        do_reset();
        check_idle("R1");
        build();
        run_to(done_cyc + 20);

        // Configuration B: complementary field values, then reset just after the DLL reset write.
        cfg_burst_len = 3'b101; cfg_burst_interleave = 1'b1; cfg_cas_lat = 3'b010;
        cfg_write_rec = 3'b100; cfg_pd_slow_exit = 1'b0; cfg_add_lat = 3'b101;
        cfg_drive_reduced = 1'b1; cfg_dqs_diff_off = 1'b0; cfg_srt_hot = 1'b0;
        do_reset();
        check_idle("R11");
        build();
        run_to(dll_cyc + 50);
        do_reset();
        check_idle("R11");
        // Full restart: the lock window must start again from the new DLL reset write (R11, R10).
        build();
        run_to(done_cyc + 20);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule